// File: doc/BRIEF.md
# Multi-Mode SHA-2 Message Schedule Generator

This block feeds a SHA-2 round engine with one schedule word per round. The engine presents a padded block and a mode, pulses a load strobe, and then pulses an advance strobe each time it consumes a word. The block returns the current word with its round index. The first sixteen words come straight from the block. Every later word is derived from a sixteen-entry sliding window of earlier words.

One window serves both word sizes. In the 32-bit mode only the low half of each entry is live, the round count is 64, and the 32-bit sigma amounts apply. In the two 64-bit modes the full entries are used, the round count is 80, and the 64-bit sigma amounts apply. Padding and compression are done elsewhere.

Top module: `sha2s_sched_top`

## Requirements
- R1: After reset, valid_o=0, done_o=0 and idx_o=0.
- R2: When load_i=1 at a clock edge, the block and mode are captured. From the next cycle valid_o=1, done_o=0, idx_o=0 and w_o holds word 0.
- R3: Words 0..15 are the block's big-endian words. In 32-bit mode, word k=blk_i[511-32k -: 32], w_o[63:32]=0, and blk_i[1023:512] is ignored. In 64-bit mode, word k=blk_i[1023-64k -: 64].
- R4: Word t (t>=16) is sig1(W[t-2]) + W[t-7] + sig0(W[t-15]) + W[t-16], taken modulo 2^wordsize.
- R5: In 32-bit mode, sig0(x)=ror7^ror18^shr3 and sig1(x)=ror17^ror19^shr10.
- R6: In 64-bit mode, sig0(x)=ror1^ror8^shr7 and sig1(x)=ror19^ror61^shr6.
- R7: mode_i encoding: 0 selects 32-bit words and 64 rounds. 1 and 2 select 64-bit words and 80 rounds, and both give identical schedules. 3 behaves as 2.
- R8: An advance while valid_o=1 and idx_o is below the last index moves to the next word, with idx_o incremented by one. With neither advance nor load, w_o and idx_o hold.
- R9: An advance on the last word (idx_o=63 or 79) sets done_o=1 and valid_o=0, and idx_o keeps the last index. Later advances change nothing until the next load.
- R10: A load restarts at word 0 with the new block and mode, even in mid-run or after done, and clears done_o.
- R11: When load_i and adv_i are both high in the same cycle, the load wins and the result is word 0 of the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture block and mode, start at word 0 |
| mode_i | input | 2 | 0: 32-bit/64 rounds, 1/2/3: 64-bit/80 rounds |
| blk_i | input | 1024 | Padded block (low 512 bits used in 32-bit mode) |
| adv_i | input | 1 | Round engine consumed the current word |
| w_o | output | 64 | Current schedule word (upper half zero in 32-bit mode) |
| idx_o | output | 7 | Round index of w_o |
| valid_o | output | 1 | w_o is a live schedule word |
| done_o | output | 1 | All words of the block have been delivered |

## Verification
Each block's full word sequence is compared against an independent model in every mode. A wrong tap position, a wrong rotate amount, or a missing 32-bit truncation would corrupt word 16 onward. A known vector in which words 16 and 17 follow from words 0 and 15 catches this quickly. The last-word boundary is tested in both word sizes: an off-by-one counter would deliver 63 or 81 words, or let idx_o move after done. Reloads in mid-run, reloads that coincide with an advance, and stalls between advances are also tested. A design that ignores them would continue the old schedule or skip a word.

// File: rtl/sha2s_pkg.sv
package sha2s_pkg;
  localparam int WORD_MAX   = 64;
  localparam int WIN_DEPTH  = 16;
  localparam int BLK_MAX    = WORD_MAX * WIN_DEPTH;
  localparam int IDX_W      = 7;
  localparam int ROUNDS_32  = 64;
  localparam int ROUNDS_64  = 80;

  typedef enum logic [1:0] {
    MODE_W32  = 2'd0,
    MODE_W64A = 2'd1,
    MODE_W64B = 2'd2,
    MODE_W64C = 2'd3
  } sched_mode_e;

  // sigma amounts, 32-bit words
  localparam int S0_R_A_32 = 7;
  localparam int S0_R_B_32 = 18;
  localparam int S0_SH_32  = 3;
  localparam int S1_R_A_32 = 17;
  localparam int S1_R_B_32 = 19;
  localparam int S1_SH_32  = 10;
  // sigma amounts, 64-bit words
  localparam int S0_R_A_64 = 1;
  localparam int S0_R_B_64 = 8;
  localparam int S0_SH_64  = 7;
  localparam int S1_R_A_64 = 19;
  localparam int S1_R_B_64 = 61;
  localparam int S1_SH_64  = 6;
endpackage

// File: rtl/sha2s_sigma.sv
module sha2s_sigma
  import sha2s_pkg::*;
#(
  parameter int W = WORD_MAX
) (
  input  logic         wide,
  input  logic [W-1:0] w_m16,
  input  logic [W-1:0] w_m15,
  input  logic [W-1:0] w_m7,
  input  logic [W-1:0] w_m2,
  output logic [W-1:0] w_new
);
  localparam int H = W / 2;

  function automatic logic [H-1:0] ror_h(input logic [H-1:0] v, input int n);
    return (v >> n) | (v << (H - n));
  endfunction

  function automatic logic [W-1:0] ror_f(input logic [W-1:0] v, input int n);
    return (v >> n) | (v << (W - n));
  endfunction

  logic [H-1:0] s0_h, s1_h, sum_h;
  logic [W-1:0] s0_f, s1_f, sum_f;

  always_comb begin
    s0_h  = ror_h(w_m15[H-1:0], S0_R_A_32) ^ ror_h(w_m15[H-1:0], S0_R_B_32)
          ^ (w_m15[H-1:0] >> S0_SH_32);
    s1_h  = ror_h(w_m2[H-1:0], S1_R_A_32) ^ ror_h(w_m2[H-1:0], S1_R_B_32)
          ^ (w_m2[H-1:0] >> S1_SH_32);
    sum_h = s1_h + w_m7[H-1:0] + s0_h + w_m16[H-1:0];

    s0_f  = ror_f(w_m15, S0_R_A_64) ^ ror_f(w_m15, S0_R_B_64) ^ (w_m15 >> S0_SH_64);
    s1_f  = ror_f(w_m2, S1_R_A_64) ^ ror_f(w_m2, S1_R_B_64) ^ (w_m2 >> S1_SH_64);
    sum_f = s1_f + w_m7 + s0_f + w_m16;

    w_new = wide ? sum_f : {{(W-H){1'b0}}, sum_h};
  end
endmodule

// File: rtl/sha2s_window.sv
module sha2s_window
  import sha2s_pkg::*;
#(
  parameter int W    = WORD_MAX,
  parameter int N    = WIN_DEPTH,
  parameter int BLKW = W * N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                wide_in,
  input  logic [BLKW-1:0]     blk,
  input  logic                shift,
  input  logic [W-1:0]        nxt,
  output logic [N-1:0][W-1:0] win
);
  localparam int H     = W / 2;
  localparam int HBLKW = BLKW / 2;

  logic [N-1:0][W-1:0] ld_word;
  logic [N-1:0][W-1:0] win_d;
  logic [N-1:0][W-1:0] win_q;
  logic                win_en;

  for (genvar k = 0; k < N; k++) begin : g_ld
    assign ld_word[k] = wide_in ? blk[BLKW-1-W*k -: W]
                                : {{(W-H){1'b0}}, blk[HBLKW-1-H*k -: H]};
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_sh
    assign win_d[k] = load ? ld_word[k] : win_q[k+1];
  end
  assign win_d[N-1] = load ? ld_word[N-1] : nxt;

  assign win_en = load | shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (win_en) begin
      win_q <= win_d;
    end
  end

  assign win = win_q;
endmodule

// File: rtl/sha2s_ctrl.sv
module sha2s_ctrl
  import sha2s_pkg::*;
#(
  parameter int IW    = IDX_W,
  parameter int RN32  = ROUNDS_32,
  parameter int RN64  = ROUNDS_64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          wide_in,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          valid,
  output logic          done,
  output logic          wide,
  output logic          shift
);
  localparam logic [IW-1:0] LAST32 = IW'(RN32 - 1);
  localparam logic [IW-1:0] LAST64 = IW'(RN64 - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic          valid_q, valid_d;
  logic          done_q, done_d;
  logic          wide_q, wide_d;
  logic          at_last;
  logic          step;

  assign at_last = (idx_q == (wide_q ? LAST64 : LAST32));
  assign step    = !load && valid_q && adv;

  always_comb begin
    idx_d   = idx_q;
    valid_d = valid_q;
    done_d  = done_q;
    wide_d  = wide_q;
    if (load) begin
      idx_d   = '0;
      valid_d = 1'b1;
      done_d  = 1'b0;
      wide_d  = wide_in;
    end else if (step) begin
      if (at_last) begin
        valid_d = 1'b0;
        done_d  = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      wide_q  <= 1'b0;
    end else begin
      idx_q   <= idx_d;
      valid_q <= valid_d;
      done_q  <= done_d;
      wide_q  <= wide_d;
    end
  end

  assign shift = step && !at_last;
  assign idx   = idx_q;
  assign valid = valid_q;
  assign done  = done_q;
  assign wide  = wide_q;
endmodule

// File: rtl/sha2s_sched_top.sv
module sha2s_sched_top
  import sha2s_pkg::*;
#(
  parameter int W    = WORD_MAX,
  parameter int N    = WIN_DEPTH,
  parameter int IW   = IDX_W,
  parameter int RN32 = ROUNDS_32,
  parameter int RN64 = ROUNDS_64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [1:0]      mode_i,
  input  logic [W*N-1:0]  blk_i,
  input  logic            adv_i,
  output logic [W-1:0]    w_o,
  output logic [IW-1:0]   idx_o,
  output logic            valid_o,
  output logic            done_o
);
  localparam int BLKW = W * N;

  logic [1:0]          rst_sync;
  logic                rst_int_n;
  logic                wide_in;
  logic                wide_q;
  logic                shift;
  logic [N-1:0][W-1:0] win;
  logic [W-1:0]        nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign wide_in = (sched_mode_e'(mode_i) != MODE_W32);

  sha2s_ctrl #(.IW(IW), .RN32(RN32), .RN64(RN64)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .load(load_i), .wide_in(wide_in),
    .adv(adv_i), .idx(idx_o), .valid(valid_o), .done(done_o),
    .wide(wide_q), .shift(shift)
  );

  sha2s_window #(.W(W), .N(N), .BLKW(BLKW)) u_win (
    .clk(clk), .rst_n(rst_int_n), .load(load_i), .wide_in(wide_in),
    .blk(blk_i), .shift(shift), .nxt(nxt), .win(win)
  );

  sha2s_sigma #(.W(W)) u_sig (
    .wide(wide_q), .w_m16(win[0]), .w_m15(win[1]), .w_m7(win[9]),
    .w_m2(win[14]), .w_new(nxt)
  );

  assign w_o = win[0];
endmodule

// File: rtl/sha2s_sched_chk.sv
module sha2s_sched_chk
  import sha2s_pkg::*;
(
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic         adv_i,
  input logic         wide,
  input logic [63:0]  w_o,
  input logic [6:0]   idx_o,
  input logic         valid_o,
  input logic         done_o
);
  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (valid_o && !done_o && idx_o == 7'd0));

  assert_narrow_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !wide) |-> (w_o[63:32] == 32'h0));

  assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o <= (wide ? 7'd79 : 7'd63));

  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && valid_o && adv_i && idx_o != (wide ? 7'd79 : 7'd63))
      |=> (idx_o == $past(idx_o) + 7'd1) && valid_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(w_o) && $stable(idx_o) && $stable(valid_o)));

  assert_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && valid_o && adv_i && idx_o == (wide ? 7'd79 : 7'd63))
      |=> (done_o && !valid_o && $stable(idx_o)));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (done_o && $stable(idx_o)));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && done_o));
endmodule

bind sha2s_sched_top sha2s_sched_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .load_i(load_i), .adv_i(adv_i),
  .wide(wide_q), .w_o(w_o), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
);

// File: tb/sim_sha2s_sched_top.sv
module sim_sha2s_sched_top;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [1023:0] blk_i = '0;
  logic          adv_i = 1'b0;
  logic [63:0]   w_o;
  logic [6:0]    idx_o;
  logic          valid_o;
  logic          done_o;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_w [0:79];
  logic [1023:0] abc_blk;
  logic [1023:0] pat_blk;
  logic [1023:0] pat2_blk;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha2s_sched_top u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i), .blk_i(blk_i),
    .adv_i(adv_i), .w_o(w_o), .idx_o(idx_o), .valid_o(valid_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] r32(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [63:0] r64(input logic [63:0] x, input int n);
    logic [127:0] d;
    d = {x, x} >> n;
    return d[63:0];
  endfunction

  // independent model of the schedule (R3..R6)
  task automatic build_ref(input logic [1023:0] b, input bit m64);
    for (int t = 0; t < 80; t++) begin
      if (t < 16) begin
        if (m64) exp_w[t] = b[1023-64*t -: 64];
        else     exp_w[t] = {32'h0, b[511-32*t -: 32]};
      end else if (m64) begin
        exp_w[t] = (r64(exp_w[t-2], 19) ^ r64(exp_w[t-2], 61) ^ (exp_w[t-2] >> 6))
                 + exp_w[t-7]
                 + (r64(exp_w[t-15], 1) ^ r64(exp_w[t-15], 8) ^ (exp_w[t-15] >> 7))
                 + exp_w[t-16];
      end else begin
        logic [31:0] a, c, s;
        a = exp_w[t-2][31:0];
        c = exp_w[t-15][31:0];
        s = (r32(a, 17) ^ r32(a, 19) ^ (a >> 10)) + exp_w[t-7][31:0]
          + (r32(c, 7) ^ r32(c, 18) ^ (c >> 3)) + exp_w[t-16][31:0];
        exp_w[t] = {32'h0, s};
      end
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic do_load(input logic [1023:0] b, input logic [1:0] m);
    blk_i = b; mode_i = m; load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_adv();
    adv_i = 1'b1;
    @(negedge clk);
    adv_i = 1'b0;
  endtask

  task automatic run_full(input logic [1023:0] b, input logic [1:0] m, input string req);
    int last;
    bit m64;
    m64 = (m != 2'd0);
    last = m64 ? 79 : 63;
    build_ref(b, m64);
    do_load(b, m);
    chk("R2 valid after load", {63'h0, valid_o}, 64'h1);
    for (int t = 0; t <= last; t++) begin
      chk({req, " word"}, w_o, exp_w[t]);
      chk("R8 index", {57'h0, idx_o}, 64'(t));
      do_adv();
    end
    chk("R9 done after last word", {62'h0, done_o, valid_o}, 64'h2);
    chk("R9 index held at last", {57'h0, idx_o}, 64'(last));
  endtask

  task automatic t_reset();
    chk("R1 valid reset", {63'h0, valid_o}, 64'h0);
    chk("R1 done reset", {63'h0, done_o}, 64'h0);
    chk("R1 idx reset", {57'h0, idx_o}, 64'h0);
  endtask

  task automatic t_abc_narrow();
    run_full(abc_blk, 2'd0, "R4 R5 32-bit");
    // spot values: W0, W15, W16, W17 of the known block
    build_ref(abc_blk, 1'b0);
    chk("R3 word0 literal", exp_w[0], 64'h0000_0000_6162_6380);
    chk("R5 word17 literal", exp_w[17], 64'h0000_0000_000F_0000);
    do_load(abc_blk, 2'd0);
    chk("R3 upper half ignored", w_o, 64'h0000_0000_6162_6380);
    for (int t = 0; t < 17; t++) do_adv();
    chk("R5 word17 from design", w_o, 64'h0000_0000_000F_0000);
  endtask

  task automatic t_wide_modes();
    run_full(pat_blk, 2'd2, "R4 R6 64-bit mode2");
    run_full(pat_blk, 2'd1, "R7 64-bit mode1");
    run_full(pat2_blk, 2'd3, "R7 64-bit mode3");
  endtask

  task automatic t_stall();
    build_ref(pat2_blk, 1'b0);
    do_load(pat2_blk, 2'd0);
    for (int t = 0; t < 20; t++) begin
      repeat (3) @(negedge clk);
      chk("R8 hold without advance", w_o, exp_w[t]);
      do_adv();
    end
    chk("R8 after stalls", w_o, exp_w[20]);
  endtask

  task automatic t_done_ignore();
    run_full(pat2_blk, 2'd0, "R4 narrow second pattern");
    do_adv();
    do_adv();
    chk("R9 advance ignored idx", {57'h0, idx_o}, 64'd63);
    chk("R9 advance ignored done", {62'h0, done_o, valid_o}, 64'h2);
    do_load(pat_blk, 2'd1);
    build_ref(pat_blk, 1'b1);
    chk("R10 reload after done", w_o, exp_w[0]);
    chk("R10 done cleared", {62'h0, done_o, valid_o}, 64'h1);
  endtask

  task automatic t_reload_mid();
    do_load(pat_blk, 2'd2);
    for (int t = 0; t < 30; t++) do_adv();
    build_ref(abc_blk, 1'b0);
    do_load(abc_blk, 2'd0);
    chk("R10 mid-run restart idx", {57'h0, idx_o}, 64'h0);
    chk("R10 mid-run restart word", w_o, exp_w[0]);
    for (int t = 0; t < 63; t++) do_adv();
    chk("R10 new mode round count", {57'h0, idx_o}, 64'd63);
    chk("R10 new mode last word", w_o, exp_w[63]);
  endtask

  task automatic t_load_vs_adv();
    do_load(pat_blk, 2'd2);
    do_adv();
    do_adv();
    build_ref(pat2_blk, 1'b1);
    blk_i = pat2_blk; mode_i = 2'd2; load_i = 1'b1; adv_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; adv_i = 1'b0;
    chk("R11 load wins idx", {57'h0, idx_o}, 64'h0);
    chk("R11 load wins word", w_o, exp_w[0]);
    do_adv();
    chk("R11 next word", w_o, exp_w[1]);
  endtask

  initial begin
    abc_blk = {512{2'b10}};
    abc_blk[511:0] = '0;
    abc_blk[511 -: 32] = 32'h6162_6380;
    abc_blk[31:0] = 32'h0000_0018;
    for (int i = 0; i < 32; i++) begin
      pat_blk[i*32 +: 32]  = (32'h9E37_79B9 * (i + 1)) ^ 32'h0F1E_2D3C;
      pat2_blk[i*32 +: 32] = (32'h85EB_CA6B * (i + 3)) ^ {i[7:0], 24'hA5C3E1};
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_abc_narrow();
    t_wide_modes();
    t_stall();
    t_done_ignore();
    t_reload_mid();
    t_load_vs_adv();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule